// File: doc/BRIEF.md
# Converter Serial Command Interface

This block is the device-side digital port of a 20-bit sampling converter. A host frames each transaction with an active-low select, clocks it with a serial clock, sends a command on the data-in line and collects replies on the data-out line. The command opens with a start bit. When that bit is set, a four-bit address and a direction bit follow. The block then writes or returns the 16-bit mode register, or it returns the latest 20-bit conversion result or an 8-bit identification value. When the first bit is clear, no command follows and the block simply streams out the latest result.

The conversion engine itself is outside this block. A convert-start pin launches a conversion. The engine then reports completion with a one-cycle done pulse and a parallel result word, which the block latches. While the select is high, the data-out line carries a busy flag. Its falling edge tells the host that a fresh result is ready.

All serial pins are oversampled by the block's own clock through a parameterised synchronizer, and edges are detected from the synchronized copies. The mode register value is presented in parallel to the rest of the chip.

Top module: `converter_serial_if`

## Requirements
- R1: After reset the mode output is 0x0000, the stored result is zero and, with select high, data-out is low.
- R2: A transaction whose first sampled data-in bit is 0 returns the stored 20-bit result, most significant bit first. The result bit k (counting from the MSB, k = 0..19) appears after falling serial edge k+1 of the transaction.
- R3: A command is the bits start = 1, address bit 3 down to address bit 0, then a direction bit (1 = read, 0 = write), in that order. The data field follows on the very next serial bit.
- R4: Reading address 4'b0001 returns the 16-bit mode register, MSB first, starting right after the falling edge that follows the direction bit.
- R5: Writing address 4'b0001 takes 16 data bits, MSB first. The mode output changes only after the 16th data bit has been sampled, and it then holds exactly those bits.
- R6: Reading address 4'b0010 returns the 20-bit stored result, MSB first.
- R7: Reading address 4'b0100 returns 8 bits whose upper four bits are 0 and whose lower four bits are 4'b1001.
- R8: A write to any address other than 4'b0001 leaves the mode output unchanged. A read of an address other than 4'b0001, 4'b0010 or 4'b0100 returns only zeros.
- R9: Once the data field of a transaction is complete, data-out stays low for the rest of that transaction, whatever further serial clocks arrive.
- R10: With select high, data-out goes high after a rising convert-start, and it goes low in the cycle after the done pulse. The done pulse also stores the parallel result word.
- R11: Raising select before the 16th write data bit discards the write, and the mode output keeps its previous value.
- R12: Data-in is sampled on rising serial edges, and data-out changes only on falling serial edges while select is low. Each serial pin passes through SYNC_STAGES flops plus one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command and write data |
| convst | input | 1 | Convert-start; a rising edge launches a conversion |
| conv_done | input | 1 | One-cycle pulse from the conversion engine at completion |
| conv_data | input | RES_W | Parallel conversion result, valid with conv_done |
| dout | output | 1 | Serial reply data while selected, busy flag otherwise |
| mode_q | output | MODE_W | Current mode register value |

## Verification
A serial edge reaches the block's state SYNC_STAGES+1 clocks after the pin moves, which is three clocks at the defaults. The bench therefore holds each serial half-period for eight clocks and samples data-out just before each rising serial edge, where the reply bit presented by the previous falling edge has long settled. The mode output is checked a full half-period after the last rising edge of a write or after select is released. The busy flag is checked eight clocks after convert-start, which is past its three-clock path, and two clocks after the done pulse, which has a one-register path.

// File: rtl/cvif_pkg.sv
package cvif_pkg;

   localparam int CMD_ADDR_W = 4;

   localparam logic [CMD_ADDR_W-1:0] ADDR_MODE   = 4'b0001;
   localparam logic [CMD_ADDR_W-1:0] ADDR_RESULT = 4'b0010;
   localparam logic [CMD_ADDR_W-1:0] ADDR_IDENT  = 4'b0100;

   localparam logic [3:0] IDENT_CODE = 4'b1001;

   typedef enum logic [2:0] {
      PH_WAIT  = 3'd0,
      PH_CMD   = 3'd1,
      PH_READ  = 3'd2,
      PH_WRITE = 3'd3,
      PH_DONE  = 3'd4
   } cvif_phase_e;

endpackage

// File: rtl/cvif_sync.sv
// Multi-bit input synchronizer; STAGES = 0 gives a plain pass-through.
module cvif_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("cvif_sync: WIDTH must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("cvif_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_st
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
      assign q = stage_q[STAGES-1];
   end

endmodule

// File: rtl/cvif_regs.sv
// Mode register, result latch, busy flag and left-aligned readback mux.
module cvif_regs
   import cvif_pkg::*;
#(
   parameter int RES_W   = 20,
   parameter int MODE_W  = 16,
   parameter int ID_W    = 8,
   parameter int SHIFT_W = RES_W,
   parameter int LEN_W   = $clog2(SHIFT_W + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  conv_start,
   input  logic                  conv_done,
   input  logic [RES_W-1:0]      conv_data,
   input  logic                  wr_strobe,
   input  logic [CMD_ADDR_W-1:0] wr_addr,
   input  logic [MODE_W-1:0]     wr_data,
   input  logic [CMD_ADDR_W-1:0] rd_addr,
   output logic [SHIFT_W-1:0]    rd_data,
   output logic [LEN_W-1:0]      rd_len,
   output logic                  rd_hit,
   output logic [MODE_W-1:0]     mode_q,
   output logic                  busy_q
);

   localparam int MODE_PAD = SHIFT_W - MODE_W;
   localparam int RES_PAD  = SHIFT_W - RES_W;
   localparam int ID_PAD   = SHIFT_W - ID_W;

   logic [RES_W-1:0]   result_q;
   logic [ID_W-1:0]    ident_val;
   logic [SHIFT_W-1:0] mode_al;
   logic [SHIFT_W-1:0] res_al;
   logic [SHIFT_W-1:0] id_al;

   assign ident_val = ID_W'(IDENT_CODE);

   // Only the mode register is writable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mode_q <= '0;
      else if (wr_strobe && wr_addr == ADDR_MODE) mode_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         result_q <= '0;
      else if (conv_done) result_q <= conv_data;
   end

   // Busy flag: a new start wins over a simultaneous done
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy_q <= 1'b0;
      else if (conv_start) busy_q <= 1'b1;
      else if (conv_done)  busy_q <= 1'b0;
   end

   assign mode_al = SHIFT_W'(mode_q)    << MODE_PAD;
   assign res_al  = SHIFT_W'(result_q)  << RES_PAD;
   assign id_al   = SHIFT_W'(ident_val) << ID_PAD;

   always_comb begin
      rd_data = '0;
      rd_len  = '0;
      rd_hit  = 1'b0;
      unique case (rd_addr)
         ADDR_MODE: begin
            rd_data = mode_al;
            rd_len  = LEN_W'(MODE_W);
            rd_hit  = 1'b1;
         end
         ADDR_RESULT: begin
            rd_data = res_al;
            rd_len  = LEN_W'(RES_W);
            rd_hit  = 1'b1;
         end
         ADDR_IDENT: begin
            rd_data = id_al;
            rd_len  = LEN_W'(ID_W);
            rd_hit  = 1'b1;
         end
         default: begin
            rd_data = '0;
            rd_len  = '0;
            rd_hit  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/cvif_serial.sv
// Command decoder and shift engine, advanced by detected serial edges.
module cvif_serial
   import cvif_pkg::*;
#(
   parameter int MODE_W  = 16,
   parameter int SHIFT_W = 20,
   parameter int LEN_W   = $clog2(SHIFT_W + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  active,
   input  logic                  rise,
   input  logic                  fall,
   input  logic                  din_s,
   input  logic [SHIFT_W-1:0]    rd_data,
   input  logic [LEN_W-1:0]      rd_len,
   input  logic                  rd_hit,
   output logic [CMD_ADDR_W-1:0] rd_addr,
   output logic                  wr_strobe,
   output logic [CMD_ADDR_W-1:0] wr_addr,
   output logic [MODE_W-1:0]     wr_data,
   output logic                  dout_q,
   output cvif_phase_e           phase_q
);

   localparam logic [LEN_W-1:0] LAST_ADDR = LEN_W'(CMD_ADDR_W);
   localparam logic [LEN_W-1:0] LAST_WR   = LEN_W'(MODE_W - 1);

   logic [LEN_W-1:0]      cnt_q;
   logic [LEN_W-1:0]      left_q;
   logic [CMD_ADDR_W-1:0] addr_q;
   logic [SHIFT_W-1:0]    sh_q;
   logic [MODE_W-1:0]     wsh_q;

   // A bare readout is served through the same readback port
   assign rd_addr   = (phase_q == PH_WAIT) ? ADDR_RESULT : addr_q;
   assign wr_addr   = addr_q;
   assign wr_data   = {wsh_q[MODE_W-2:0], din_s};
   assign wr_strobe = active && rise && phase_q == PH_WRITE && cnt_q == LAST_WR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_WAIT;
         cnt_q   <= '0;
         left_q  <= '0;
         addr_q  <= '0;
         sh_q    <= '0;
         wsh_q   <= '0;
         dout_q  <= 1'b0;
      end else if (!active) begin
         phase_q <= PH_WAIT;
         cnt_q   <= '0;
         left_q  <= '0;
         dout_q  <= 1'b0;
      end else if (rise) begin
         unique case (phase_q)
            PH_WAIT: begin
               if (din_s) begin
                  phase_q <= PH_CMD;
                  cnt_q   <= '0;
                  addr_q  <= '0;
               end else begin
                  phase_q <= PH_READ;
                  sh_q    <= rd_data;
                  left_q  <= rd_len;
               end
            end
            PH_CMD: begin
               if (cnt_q < LAST_ADDR) begin
                  addr_q <= {addr_q[CMD_ADDR_W-2:0], din_s};
                  cnt_q  <= cnt_q + 1'b1;
               end else if (din_s) begin
                  if (rd_hit) begin
                     phase_q <= PH_READ;
                     sh_q    <= rd_data;
                     left_q  <= rd_len;
                  end else begin
                     phase_q <= PH_DONE;
                  end
               end else begin
                  phase_q <= PH_WRITE;
                  cnt_q   <= '0;
               end
            end
            PH_WRITE: begin
               wsh_q <= {wsh_q[MODE_W-2:0], din_s};
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_WR) phase_q <= PH_DONE;
            end
            default: begin
               phase_q <= phase_q;
            end
         endcase
      end else if (fall && phase_q == PH_READ) begin
         if (left_q != '0) begin
            dout_q <= sh_q[SHIFT_W-1];
            sh_q   <= {sh_q[SHIFT_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
         end else begin
            dout_q  <= 1'b0;
            phase_q <= PH_DONE;
         end
      end
   end

endmodule

// File: rtl/converter_serial_if.sv
module converter_serial_if
   import cvif_pkg::*;
#(
   parameter int RES_W       = 20,
   parameter int MODE_W      = 16,
   parameter int ID_W        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              din,
   input  logic              convst,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data,
   output logic              dout,
   output logic [MODE_W-1:0] mode_q
);

   localparam int SHIFT_W = RES_W;
   localparam int LEN_W   = $clog2(SHIFT_W + 1);

   if (MODE_W < 2 || MODE_W > RES_W) begin : g_bad_mode
      $error("converter_serial_if: MODE_W must lie in 2..RES_W");
   end
   if (ID_W < 4 || ID_W > RES_W) begin : g_bad_id
      $error("converter_serial_if: ID_W must lie in 4..RES_W");
   end

   logic [3:0] pins_s;
   logic       cs_s, sclk_s, din_s, conv_s;
   logic       sclk_p, conv_p;
   logic       active, rise, fall, conv_start;

   cvif_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, din, convst}),
      .q     (pins_s)
   );

   assign {cs_s, sclk_s, din_s, conv_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= 1'b0;
         conv_p <= 1'b0;
      end else begin
         sclk_p <= sclk_s;
         conv_p <= conv_s;
      end
   end

   assign active     = ~cs_s;
   assign rise       = sclk_s & ~sclk_p;
   assign fall       = ~sclk_s & sclk_p;
   assign conv_start = conv_s & ~conv_p;

   logic [CMD_ADDR_W-1:0] rd_addr, wr_addr;
   logic [SHIFT_W-1:0]    rd_data;
   logic [LEN_W-1:0]      rd_len;
   logic                  rd_hit, wr_strobe, busy_q, dout_q;
   logic [MODE_W-1:0]     wr_data;
   cvif_phase_e           phase_q;

   cvif_regs #(
      .RES_W(RES_W), .MODE_W(MODE_W), .ID_W(ID_W), .SHIFT_W(SHIFT_W), .LEN_W(LEN_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_start (conv_start),
      .conv_done  (conv_done),
      .conv_data  (conv_data),
      .wr_strobe  (wr_strobe),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .rd_len     (rd_len),
      .rd_hit     (rd_hit),
      .mode_q     (mode_q),
      .busy_q     (busy_q)
   );

   cvif_serial #(.MODE_W(MODE_W), .SHIFT_W(SHIFT_W), .LEN_W(LEN_W)) u_serial (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .rise      (rise),
      .fall      (fall),
      .din_s     (din_s),
      .rd_data   (rd_data),
      .rd_len    (rd_len),
      .rd_hit    (rd_hit),
      .rd_addr   (rd_addr),
      .wr_strobe (wr_strobe),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .dout_q    (dout_q),
      .phase_q   (phase_q)
   );

   // Selected: serial reply; deselected: busy flag, whose fall marks end of conversion
   assign dout = active ? dout_q : busy_q;

endmodule

// File: rtl/cvif_chk.sv
module cvif_chk
   import cvif_pkg::*;
#(
   parameter int MODE_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  active,
   input logic                  fall,
   input logic                  conv_start,
   input logic                  conv_done,
   input logic                  busy_q,
   input logic                  wr_strobe,
   input logic [CMD_ADDR_W-1:0] wr_addr,
   input logic [MODE_W-1:0]     wr_data,
   input logic [MODE_W-1:0]     mode_q,
   input cvif_phase_e           phase_q,
   input logic                  dout
);

   // R5, R8, R11: the mode register moves only on a committed mode write
   a_r5_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_strobe && wr_addr == ADDR_MODE) |=> $stable(mode_q));

   // R5: the committed value is the assembled write word
   a_r5_mode_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && wr_addr == ADDR_MODE) |=> mode_q == $past(wr_data));

   // R10: convert-start raises the busy flag
   a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> busy_q);

   // R10: completion clears the busy flag
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !conv_start) |=> !busy_q);

   // R9: data-out is low once the data field has finished
   a_r9_done_low: assert property (@(posedge clk) disable iff (!rst_n)
      (active && phase_q == PH_DONE) |-> !dout);

   // R12: while selected, data-out only moves after a falling serial edge
   a_r12_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && !$past(fall)) |-> $stable(dout));

endmodule

bind converter_serial_if cvif_chk #(.MODE_W(MODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .active     (active),
   .fall       (fall),
   .conv_start (conv_start),
   .conv_done  (conv_done),
   .busy_q     (busy_q),
   .wr_strobe  (wr_strobe),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .mode_q     (mode_q),
   .phase_q    (phase_q),
   .dout       (dout)
);

// File: tb/converter_serial_if_tb.sv
`timescale 1ns/1ps
module converter_serial_if_tb;

   localparam int RES_W  = 20;
   localparam int MODE_W = 16;
   localparam int ID_W   = 8;
   localparam int HP     = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, convst = 1'b0, conv_done = 1'b0;
   logic [RES_W-1:0]  conv_data = '0;
   logic              dout;
   logic [MODE_W-1:0] mode_q;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // Behavioural model state
   logic [MODE_W-1:0] m_mode = '0;
   logic [RES_W-1:0]  m_result = '0;

   always #2 clk = ~clk;

   converter_serial_if u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .convst(convst), .conv_done(conv_done), .conv_data(conv_data),
      .dout(dout), .mode_q(mode_q)
   );

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R12: din set a half-period before each rise; dout sampled just before the rise
   task automatic xfer(input logic [63:0] tx, input int n, output logic [63:0] rx);
      rx = '0;
      cs_n = 1'b0;
      clks(HP);
      for (int i = 0; i < n; i++) begin
         din = tx[i];
         clks(HP);
         rx[i] = dout;
         sclk = 1'b1;
         clks(HP);
         sclk = 1'b0;
      end
      clks(HP);
      cs_n = 1'b1;
      din = 1'b0;
      clks(HP);
   endtask

   // R3: start, address MSB first, direction, then data MSB first
   function automatic logic [63:0] cmd_bits(input logic [3:0] a, input bit rd,
                                            input logic [15:0] wd);
      logic [63:0] v = '0;
      v[0] = 1'b1;
      for (int k = 0; k < 4; k++) v[1+k] = a[3-k];
      v[5] = rd;
      for (int k = 0; k < 16; k++) v[6+k] = wd[15-k];
      return v;
   endfunction

   function automatic logic [63:0] exp_stream(input int lead, input logic [31:0] d,
                                              input int w);
      logic [63:0] v = '0;
      for (int k = 0; k < w; k++) v[lead+1+k] = d[w-1-k];
      return v;
   endfunction

   task automatic read_reg(input logic [3:0] a, input int w, input logic [31:0] expd,
                           input string req);
      logic [63:0] rx;
      xfer(cmd_bits(a, 1'b1, 16'h0), 6 + w + 3, rx);
      check(req, rx, exp_stream(5, expd, w), "read stream");
   endtask

   task automatic write_reg(input logic [3:0] a, input logic [15:0] wd, input int nbits);
      logic [63:0] rx;
      xfer(cmd_bits(a, 1'b0, wd), nbits, rx);
      if (a == 4'b0001 && nbits >= 22) m_mode = wd;
   endtask

   task automatic do_conv(input logic [RES_W-1:0] d);
      convst = 1'b1;
      clks(4);
      convst = 1'b0;
      clks(4);
      check("R10", 64'(dout), 64'd1, "busy after convert-start");
      clks(6);
      conv_data = d;
      conv_done = 1'b1;
      clks(1);
      conv_done = 1'b0;
      m_result = d;
      clks(2);
      check("R10", 64'(dout), 64'd0, "dout low after done");
   endtask

   task automatic readout(input string req);
      logic [63:0] rx;
      xfer(64'h0, RES_W + 4, rx);
      check(req, rx, exp_stream(0, 32'(m_result), RES_W), "bare readout stream");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      clks(5);
      rst_n = 1'b1;
      clks(5);
      // R1: reset state
      check("R1", 64'(mode_q), 64'h0, "mode after reset");
      check("R1", 64'(dout), 64'h0, "dout after reset");
      // R1/R2: readout of the reset result is all zeros
      readout("R1");

      // R10: conversion, then R2 bare readout and R9 trailing zeros
      do_conv(20'hA3C5E);
      readout("R2");
      // R6: result via command
      read_reg(4'b0010, RES_W, 32'(m_result), "R6");
      // R7: identification value
      read_reg(4'b0100, ID_W, 32'h09, "R7");
      // R4: mode reads back its reset value
      read_reg(4'b0001, MODE_W, 32'(m_mode), "R4");

      // R11/R5: abort after 15 data bits leaves mode unchanged
      write_reg(4'b0001, 16'hBEEF, 6 + 15);
      check("R11", 64'(mode_q), 64'(m_mode), "mode after aborted write");
      // R5: full write
      write_reg(4'b0001, 16'hA5C3, 6 + 16 + 2);
      check("R5", 64'(mode_q), 64'(m_mode), "mode after full write");
      read_reg(4'b0001, MODE_W, 32'(m_mode), "R4");

      // R8: writes elsewhere are ignored
      write_reg(4'b1000, 16'h1234, 6 + 16);
      check("R8", 64'(mode_q), 64'(m_mode), "mode after reserved write");
      write_reg(4'b0100, 16'h00FF, 6 + 16);
      check("R8", 64'(mode_q), 64'(m_mode), "mode after write to ID");
      read_reg(4'b0100, ID_W, 32'h09, "R8");
      write_reg(4'b0010, 16'h5555, 6 + 16);
      read_reg(4'b0010, RES_W, 32'(m_result), "R8");
      // R8: reserved read returns zeros
      read_reg(4'b1111, ID_W, 32'h0, "R8");

      // Boundary results: all ones and MSB/LSB only
      do_conv(20'hFFFFF);
      readout("R2");
      do_conv(20'h80001);
      readout("R2");
      read_reg(4'b0010, RES_W, 32'(m_result), "R6");
      // R5: second write overrides the first
      write_reg(4'b0001, 16'h8001, 6 + 16);
      check("R5", 64'(mode_q), 64'(m_mode), "mode after second write");

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule